// File: doc/BRIEF.md
# Ping-Pong Tile-Row Line Buffer

This block sits between a producer (a CPU or DMA engine) and the display fetch logic of a tile-mapped video pipeline that has no external tile-map memory. It holds two banks of one tile row each. A tile row is 80 tiles at two bytes per tile, so each bank holds 160 bytes. While the display fetch logic reads the descriptor bytes of the current tile row from one bank, the producer streams the next row into the other bank. The banks exchange roles once per tile row, every 8 scan lines. The producer has to deliver a full row on every pass, even when the picture does not change.

The producer port is a byte-wide valid/ready stream. A byte transfers on any cycle where `wr_valid` and `wr_ready` are both high. The producer may hold `wr_valid` high or drop it at any time. After a byte has been offered, the block places no rule on whether it must be kept. `wr_ready` depends only on internal state, never on `wr_valid`. It stays high until the fill bank holds a complete row, and then it stays low until the next swap. The display side is a plain random-access read port: a tile column and a byte select go in, and the byte comes out one clock later.

The scan-line timing comes in as a one-cycle `line_start` strobe with the current line number. If the fill bank is short of a full row when a swap happens, a sticky `underrun` flag is raised. Only `underrun_clr` lowers it again.

Top module: `tile_row_pingpong`

## Requirements
- R1: After reset, `wr_ready` is 1, `underrun` is 0 and `rd_data` is 0. Bank 0 is the display bank and bank 1 is the fill bank.
- R2: Each byte accepted (`wr_valid` and `wr_ready` high) is written into the fill bank at the next offset, counting up from 0 after each swap. The byte at offset 2*c+s is returned for column c and byte select s.
- R3: `wr_ready` is 1 while fewer than 160 bytes have been accepted since the last swap, and 0 once 160 have been accepted. While it is 0, `wr_valid` changes neither the pointer nor any stored byte.
- R4: A swap happens on the clock edge where `line_start` is 1 and `line_idx` mod 8 equals 0. At a swap the two banks exchange roles and the write pointer returns to 0. A `line_start` on any other line has no effect.
- R5: At a swap, `underrun` is set if the outgoing fill bank holds fewer than 160 bytes, and it then stays set.
- R6: `rd_data` presents the display-bank byte for (`rd_col`, `rd_sel`) one clock after they are applied. A read whose address is applied in the swap cycle returns the pre-swap display bank.
- R7: `underrun_clr` lowers `underrun` on the next edge. If a swap raises `underrun` on the same edge, the flag is set.
- R8: A byte accepted in the swap cycle is written into the outgoing fill bank at its offset and counts toward that bank's 160 bytes.
- R9: A read with `rd_col` of 80 or more returns 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer byte offered |
| wr_ready | output | 1 | Fill bank can take a byte |
| wr_data | input | 8 | Producer byte |
| line_start | input | 1 | One-cycle strobe at the start of a scan line |
| line_idx | input | 10 | Scan-line number that goes with `line_start` |
| rd_col | input | 7 | Tile column to read |
| rd_sel | input | 1 | Byte select within the tile |
| rd_data | output | 8 | Read byte, one clock after the address |
| underrun | output | 1 | Sticky flag: a swap found the fill bank incomplete |
| underrun_clr | input | 1 | Clears `underrun` |

## Verification
The bench fills a row with an irregular `wr_valid` pattern and then keeps offering bytes to a full bank. This separates the ready behaviour from the handshake and shows that refused bytes are lost. It then steps through line numbers. Strobes on lines that are not multiples of 8 must leave the banks alone, while strobes on multiples of 8 must swap them. Two rows with different contents, read back across the swap edge, show that the swap-cycle read is taken from the old bank. A short row, a row completed by the byte accepted in the swap cycle, and an empty row combined with a clear in the same cycle mark the exact edge at which the underrun flag is set.

// File: rtl/trp_pkg.sv
package trp_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/trp_bank_ram.sv
module trp_bank_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 160,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trp_row_phase.sv
module trp_row_phase #(
  parameter int LINE_W    = 10,
  parameter int ROW_LINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_idx,
  output logic              swap,
  output logic              disp_bank,
  output logic              fill_bank
);
  import trp_pkg::*;

  bank_e cur_disp;

  assign swap      = line_start && ((32'(line_idx) % ROW_LINES) == 0);
  assign disp_bank = (cur_disp == BANK_B);
  assign fill_bank = (cur_disp == BANK_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_disp <= BANK_A;
    end else if (swap) begin
      cur_disp <= (cur_disp == BANK_A) ? BANK_B : BANK_A;
    end
  end
endmodule

// File: rtl/trp_fill_ctrl.sv
module trp_fill_ctrl #(
  parameter int BANK_BYTES = 160,
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             swap,
  input  logic             underrun_clr,
  output logic             wr_ready,
  output logic             fire,
  output logic [CNT_W-1:0] fill_count,
  output logic             underrun
);
  logic row_done;

  assign wr_ready = fill_count < CNT_W'(BANK_BYTES);
  assign fire     = wr_valid && wr_ready;
  assign row_done = (fill_count + CNT_W'(fire)) == CNT_W'(BANK_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_count <= '0;
    end else if (swap) begin
      fill_count <= '0;
    end else if (fire) begin
      fill_count <= fill_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun <= 1'b0;
    end else if (swap && !row_done) begin
      underrun <= 1'b1;
    end else if (underrun_clr) begin
      underrun <= 1'b0;
    end
  end
endmodule

// File: rtl/tile_row_pingpong.sv
module tile_row_pingpong #(
  parameter int TILES          = 80,
  parameter int BYTES_PER_TILE = 2,
  parameter int ROW_LINES      = 8,
  parameter int DATA_W         = 8,
  parameter int LINE_W         = 10,
  localparam int BANK_BYTES    = TILES * BYTES_PER_TILE,
  localparam int NUM_BANKS     = 2,
  localparam int ADDR_W        = $clog2(BANK_BYTES),
  localparam int CNT_W         = $clog2(BANK_BYTES + 1),
  localparam int COL_W         = $clog2(TILES),
  localparam int SEL_W         = (BYTES_PER_TILE > 1) ? $clog2(BYTES_PER_TILE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_idx,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              underrun,
  input  logic              underrun_clr
);
  logic              swap;
  logic              disp_bank;
  logic              fill_bank;
  logic              fire;
  logic [CNT_W-1:0]  fill_count;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic              rd_oob;
  logic              oob_q;
  logic              bank_q;
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];

  trp_row_phase #(
    .LINE_W    (LINE_W),
    .ROW_LINES (ROW_LINES)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .line_idx   (line_idx),
    .swap       (swap),
    .disp_bank  (disp_bank),
    .fill_bank  (fill_bank)
  );

  trp_fill_ctrl #(
    .BANK_BYTES (BANK_BYTES)
  ) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .swap         (swap),
    .underrun_clr (underrun_clr),
    .wr_ready     (wr_ready),
    .fire         (fire),
    .fill_count   (fill_count),
    .underrun     (underrun)
  );

  assign waddr  = fill_count[ADDR_W-1:0];
  assign rd_oob = {1'b0, rd_col} >= (COL_W + 1)'(TILES);
  assign raddr  = rd_oob ? '0
                : ADDR_W'(rd_col) * ADDR_W'(BYTES_PER_TILE) + ADDR_W'(rd_sel);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    trp_bank_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (BANK_BYTES)
    ) u_ram (
      .clk   (clk),
      .we    (fire && (fill_bank == 1'(b))),
      .waddr (waddr),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (bank_rdata[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oob_q  <= 1'b1;
      bank_q <= 1'b0;
    end else begin
      oob_q  <= rd_oob;
      bank_q <= disp_bank;
    end
  end

  assign rd_data = oob_q ? '0 : bank_rdata[bank_q];
endmodule

// File: rtl/tile_row_pingpong_chk.sv
module tile_row_pingpong_chk #(
  parameter int TILES      = 80,
  parameter int BANK_BYTES = 160,
  parameter int CNT_W      = 8,
  parameter int COL_W      = 7,
  parameter int DATA_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              swap,
  input logic [CNT_W-1:0]  fill_count,
  input logic              disp_bank,
  input logic              wr_ready,
  input logic              underrun,
  input logic              underrun_clr,
  input logic [COL_W-1:0]  rd_col,
  input logic [DATA_W-1:0] rd_data
);
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !swap && fill_count == CNT_W'(BANK_BYTES - 1)) |=> !wr_ready);

  p_blocked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !swap) |=> (!wr_ready && $stable(fill_count)));

  p_swap_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (wr_ready && fill_count == '0));

  p_bank_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (disp_bank != $past(disp_bank)));

  p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(disp_bank));

  p_short_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && fill_count != CNT_W'(BANK_BYTES)
          && !(fire && fill_count == CNT_W'(BANK_BYTES - 1))) |=> underrun);

  p_underrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);

  p_underrun_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_clr && !swap) |=> !underrun);

  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rd_col} >= (COL_W + 1)'(TILES)) |=> (rd_data == '0));
endmodule

bind tile_row_pingpong tile_row_pingpong_chk #(
  .TILES      (TILES),
  .BANK_BYTES (BANK_BYTES),
  .CNT_W      (CNT_W),
  .COL_W      (COL_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fire         (fire),
  .swap         (swap),
  .fill_count   (fill_count),
  .disp_bank    (disp_bank),
  .wr_ready     (wr_ready),
  .underrun     (underrun),
  .underrun_clr (underrun_clr),
  .rd_col       (rd_col),
  .rd_data      (rd_data)
);

// File: tb/tile_row_pingpong_test.sv
module tile_row_pingpong_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 160;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       line_start = 1'b0;
  logic [9:0] line_idx = '0;
  logic [6:0] rd_col = '0;
  logic [0:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       underrun;
  logic       underrun_clr = 1'b0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  // reference model
  logic [7:0] m_mem [2][NB];
  bit         m_kn  [2][NB];
  int         m_bank;
  int         m_ptr;
  bit         m_und;
  logic [7:0] m_rd;
  bit         m_rd_kn;

  tile_row_pingpong uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .line_start(line_start), .line_idx(line_idx),
    .rd_col(rd_col), .rd_sel(rd_sel), .rd_data(rd_data),
    .underrun(underrun), .underrun_clr(underrun_clr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bank = 0; m_ptr = 0; m_und = 0; m_rd = 8'h00; m_rd_kn = 1;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NB; i++) m_kn[b][i] = 0;
    end else begin
      bit fire_m, swap_m;
      fire_m = wr_valid && (m_ptr < NB);
      if (int'(rd_col) >= 80) begin
        m_rd = 8'h00; m_rd_kn = 1;
      end else begin
        m_rd    = m_mem[m_bank][2 * int'(rd_col) + int'(rd_sel)];
        m_rd_kn = m_kn[m_bank][2 * int'(rd_col) + int'(rd_sel)];
      end
      if (fire_m) begin
        m_mem[1 - m_bank][m_ptr] = wr_data;
        m_kn[1 - m_bank][m_ptr]  = 1;
        m_ptr++;
      end
      swap_m = line_start && (int'(line_idx) % 8 == 0);
      if (swap_m && m_ptr != NB) m_und = 1;
      else if (underrun_clr) m_und = 0;
      if (swap_m) begin
        m_bank = 1 - m_bank;
        m_ptr  = 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R3 wr_ready vs model", int'(wr_ready), (m_ptr < NB) ? 1 : 0);
      check("R5 underrun vs model", int'(underrun), int'(m_und));
      if (m_rd_kn) check("R6 rd_data vs model", int'(rd_data), int'(m_rd));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int kind, input int i);
    case (kind)
      0: return 8'(i * 7 + 3);
      1: return 8'(255 - i);
      2: return 8'(i) ^ 8'h5A;
      default: return 8'(i + 64);
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // write n bytes, holding valid off every third cycle
  task automatic fill(input int n, input int kind);
    int i = 0;
    int k = 0;
    while (i < n) begin
      if (k % 3 == 2) begin
        wr_valid = 0;
      end else begin
        wr_valid = 1;
        wr_data  = pat(kind, i);
      end
      k++;
      if (wr_valid && wr_ready) i++;
      step();
    end
    wr_valid = 0;
  endtask

  task automatic line(input int idx);
    line_start = 1; line_idx = 10'(idx);
    step();
    line_start = 0;
  endtask

  task automatic read_at(input int c, input int s);
    rd_col = 7'(c); rd_sel = 1'(s);
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    cmp_on = 1;
    check("R1 reset wr_ready", int'(wr_ready), 1);
    check("R1 reset underrun", int'(underrun), 0);
    check("R1 reset rd_data", int'(rd_data), 0);

    // full row A into bank 1, then extra offers that must be refused
    fill(NB, 0);
    check("R3 ready low when full", int'(wr_ready), 0);
    wr_valid = 1; wr_data = 8'hEE;
    repeat (4) step();
    wr_valid = 0;
    check("R3 ready stays low", int'(wr_ready), 0);
    line(16);
    check("R4 ready after swap", int'(wr_ready), 1);
    check("R5 no underrun on full row", int'(underrun), 0);

    for (int c = 0; c < 80; c++)
      for (int s = 0; s < 2; s++) begin
        read_at(c, s);
        check("R2 readback row A", int'(rd_data), int'(pat(0, 2 * c + s)));
      end

    // row B into bank 0; non-multiple line must not swap
    fill(NB, 1);
    line(3);
    check("R4 no swap on line 3", int'(wr_ready), 0);
    read_at(10, 1);
    check("R4 still row A", int'(rd_data), int'(pat(0, 21)));
    // swap with read address held: swap-cycle read is from old bank
    line_start = 1; line_idx = 10'd8;
    step();
    line_start = 0;
    check("R6 swap-cycle read old bank", int'(rd_data), int'(pat(0, 21)));
    step();
    check("R6 next read new bank", int'(rd_data), int'(pat(1, 21)));
    read_at(79, 1);
    check("R2 row B last byte", int'(rd_data), int'(pat(1, 159)));

    // short row
    fill(100, 2);
    line(24);
    check("R5 underrun on short row", int'(underrun), 1);
    repeat (3) step();
    check("R5 underrun sticky", int'(underrun), 1);
    read_at(49, 1);
    check("R2 short row byte 99", int'(rd_data), int'(pat(2, 99)));
    underrun_clr = 1;
    step();
    underrun_clr = 0;
    check("R7 underrun cleared", int'(underrun), 0);

    // 159 bytes, 160th accepted in the swap cycle
    fill(159, 3);
    wr_valid = 1; wr_data = pat(3, 159);
    line_start = 1; line_idx = 10'd32;
    step();
    wr_valid = 0; line_start = 0;
    check("R8 swap-cycle byte completes row", int'(underrun), 0);
    read_at(79, 1);
    check("R8 swap-cycle byte stored", int'(rd_data), int'(pat(3, 159)));

    read_at(80, 0);
    check("R9 column 80 reads zero", int'(rd_data), 0);
    read_at(127, 1);
    check("R9 column 127 reads zero", int'(rd_data), 0);

    // empty row swap with clear in the same cycle: set wins
    underrun_clr = 1; line_start = 1; line_idx = 10'd40;
    step();
    underrun_clr = 0; line_start = 0;
    check("R7 set beats clear", int'(underrun), 1);
    underrun_clr = 1;
    step();
    underrun_clr = 0;
    check("R7 clear afterwards", int'(underrun), 0);

    repeat (2) step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule